// File: doc/BRIEF.md
# Byte-Window Fuse Read Front End

This block sits in front of a fuse reader that can only return whole words, and lets a client read any run of bytes from a fixed byte window. The client gives a byte offset and a byte length. The block checks the pair against the window. It moves the offset by a fixed base. It then asks the word reader for each word that the run touches, lowest address first, and streams back only the bytes that were asked for, in address order.

Every request ends with one status beat. A good request ends with code zero and a count equal to the requested length. A request whose arguments are out of range ends with an invalid-argument code, and the block touches neither the reader nor the byte stream. If the reader fails on a word, the block returns the reader's own code together with the number of bytes it has already delivered.

The block takes one request at a time. A new request is not accepted until the status of the previous one has been taken. The word size (block size) is a parameter with a default of 4 bytes; a block size of 1 gives plain byte-by-byte reads with no rounding.

Top module: `byte_window_reader`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1 and `byte_valid`, `stat_valid` and `wrd_req_valid` are 0.
- R2: A request whose offset, read as a two's-complement number, is negative ends with `stat_code` 22 and `stat_count` 0. It makes no word request and sends no byte.
- R3: A request whose size, read as two's complement, is zero or negative is rejected the same way as in R2 (code 22, count 0, no word request, no byte).
- R4: A request with offset + size greater than WINDOW is rejected as in R2. A request with offset + size equal to WINDOW is served.
- R5: For an accepted request, let a = offset + BASE. The word requests carry the addresses floor(a/BLOCK), floor(a/BLOCK)+1, and so on, consecutively. Their number is ceil((a+size)/BLOCK) - floor(a/BLOCK).
- R6: Byte k of the stream is the byte at byte address a+k. That byte is lane (a+k) mod BLOCK of word (a+k)/BLOCK, and lane l sits in word bits 8l+7 down to 8l (little-endian).
- R7: A served request sends exactly `size` bytes, and `byte_last` is 1 on the final byte only.
- R8: After the final byte, the status reports `stat_code` 0 and `stat_count` equal to the requested size.
- R9: When a word response carries `wrd_rsp_err`, the status reports `wrd_rsp_code` unchanged and a count equal to the bytes already sent. No further word request is made, no further byte is sent, and no byte carries `byte_last`.
- R10: `req_ready` is 1 only while the block is idle. From the accepting edge until the status handshake, no new request is taken.
- R11: While `byte_valid` is 1 and `byte_ready` is 0, the byte and its last flag stay unchanged into the next cycle.
- R12: While `wrd_req_valid` is 1 and `wrd_req_ready` is 0, the request and its address stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can take a request |
| req_offset | input | OFS_W | Byte offset in the window, two's complement |
| req_size | input | LEN_W | Byte count, two's complement |
| byte_valid | output | 1 | Stream byte present |
| byte_ready | input | 1 | Client takes the byte |
| byte_data | output | 8 | Stream byte |
| byte_last | output | 1 | Final byte of the request |
| stat_valid | output | 1 | Status present |
| stat_ready | input | 1 | Client takes the status |
| stat_code | output | 8 | 0 success, 22 bad argument, else reader code |
| stat_count | output | LEN_W | Bytes delivered |
| wrd_req_valid | output | 1 | Word read request |
| wrd_req_ready | input | 1 | Reader takes the request |
| wrd_req_addr | output | WA_W | Word (block) index |
| wrd_rsp_valid | input | 1 | Word response present (one cycle) |
| wrd_rsp_data | input | BLOCK*8 | Word contents |
| wrd_rsp_err | input | 1 | Reader failed on this word |
| wrd_rsp_code | input | 8 | Reader error code (non-zero) |

## Verification
The bench sweeps every offset and size in a range that runs past both edges of a small unaligned window. It does this with and without backpressure, so a bounds check that is off by one would accept a request at window+1 or refuse one that ends exactly at the window's edge. Runs that start part-way into a word would show up a design that forgets the base offset, rounds the end block down, or picks the wrong byte lane: it would fetch too few words, fetch the wrong ones, or send the bytes shifted. A second sweep injects a reader error on each covering word in turn. A design that kept fetching, flagged a last byte, or reported zero (or the requested size) rather than the partial count would fail there. The final status of a good run is checked for the byte count rather than a bare zero.

// File: rtl/brd_pkg.sv
// Package: shared state encoding and status codes for the byte-window reader.
// Assumes: status code 0 means success; reader error codes are non-zero.
package brd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASK,
        ST_WAIT,
        ST_SEND,
        ST_DONE
    } brd_state_e;

    localparam logic [7:0] CODE_OK     = 8'd0;
    localparam logic [7:0] CODE_BADARG = 8'd22;
endpackage

// File: rtl/brd_req_check.sv
// Module: argument check and block arithmetic for one request.
// Does: flags a negative offset, a non-positive size, or a run past the window;
//       adds the base and splits the absolute byte address into block and lane.
// Assumes: BLOCK is a power of two; LANE_W is max(1, log2(BLOCK)).
module brd_req_check #(
    parameter int OFS_W  = 8,
    parameter int LEN_W  = 8,
    parameter int WINDOW = 32,
    parameter int BASE   = 96,
    parameter int BLOCK  = 4,
    parameter int WA_W   = 6,
    parameter int LANE_W = 2
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic [LEN_W-1:0]  size,
    output logic              bad,
    output logic [WA_W-1:0]   start_blk,
    output logic [LANE_W-1:0] start_lane
);
    localparam int MAXW   = (OFS_W > LEN_W) ? OFS_W : LEN_W;
    localparam int SPAN_W = $clog2(BASE + WINDOW + 1);
    localparam int EXT    = ((MAXW > SPAN_W) ? MAXW : SPAN_W) + 1;
    localparam int LG     = $clog2(BLOCK);

    logic [EXT-1:0] ofs_u, size_u, end_u, abs_u;

    // Widen both operands and form the run end and the absolute start.
    always_comb begin
        ofs_u  = EXT'(ofs);
        size_u = EXT'(size);
        end_u  = ofs_u + size_u;
        abs_u  = ofs_u + EXT'(BASE);
        bad    = ofs[OFS_W-1] | size[LEN_W-1] | (size == '0) | (end_u > EXT'(WINDOW));
        start_blk = WA_W'(abs_u >> LG);
    end

    generate
        if (LG == 0) begin : g_byte_mode
            // Block size 1: every byte is its own block, lane is always zero.
            assign start_lane = '0;
        end else begin : g_block_mode
            // Lane is the low address bits inside the block.
            assign start_lane = abs_u[LG-1:0];
        end
    endgenerate
endmodule

// File: rtl/brd_lane_pick.sv
// Module: selects one byte lane of a fetched word, little-endian.
// Assumes: lane < BLOCK; for BLOCK == 1 the lane input is unused.
module brd_lane_pick #(
    parameter int BLOCK  = 4,
    parameter int LANE_W = 2
) (
    input  logic [BLOCK*8-1:0] word,
    input  logic [LANE_W-1:0]  lane,
    output logic [7:0]         pick
);
    generate
        if (BLOCK == 1) begin : g_single
            logic unused_lane;
            // Only one lane exists; pass it straight through.
            assign unused_lane = ^lane;
            assign pick        = word[7:0];
        end else begin : g_multi
            // Lane l occupies bits 8l+7:8l.
            always_comb pick = word[lane*8 +: 8];
        end
    endgenerate
endmodule

// File: rtl/byte_window_reader.sv
// Module: byte-granular read front end over a word-organized fuse reader.
// Does: checks a byte request against the window, adds BASE, fetches every
//       covering word in turn, streams the requested bytes, then one status.
// Assumes: one request in flight; a word response arrives as a one-cycle
//          pulse after its request was taken; reader error codes are non-zero.
module byte_window_reader
    import brd_pkg::*;
#(
    parameter int OFS_W  = 8,
    parameter int LEN_W  = 8,
    parameter int WINDOW = 32,
    parameter int BASE   = 96,
    parameter int BLOCK  = 4,
    parameter int WA_W   = $clog2((BASE + WINDOW + BLOCK - 1) / BLOCK + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [OFS_W-1:0]   req_offset,
    input  logic [LEN_W-1:0]   req_size,
    output logic               byte_valid,
    input  logic               byte_ready,
    output logic [7:0]         byte_data,
    output logic               byte_last,
    output logic               stat_valid,
    input  logic               stat_ready,
    output logic [7:0]         stat_code,
    output logic [LEN_W-1:0]   stat_count,
    output logic               wrd_req_valid,
    input  logic               wrd_req_ready,
    output logic [WA_W-1:0]    wrd_req_addr,
    input  logic               wrd_rsp_valid,
    input  logic [BLOCK*8-1:0] wrd_rsp_data,
    input  logic               wrd_rsp_err,
    input  logic [7:0]         wrd_rsp_code
);
    localparam int LG     = $clog2(BLOCK);
    localparam int LANE_W = (LG > 0) ? LG : 1;
    localparam logic [LANE_W-1:0] LANE_TOP = LANE_W'(BLOCK - 1);

    brd_state_e         state_q;
    logic [WA_W-1:0]    blk_q;
    logic [LANE_W-1:0]  lane_q;
    logic [LEN_W-1:0]   left_q, sent_q, count_q;
    logic [7:0]         code_q;
    logic [BLOCK*8-1:0] word_q;

    logic               chk_bad;
    logic [WA_W-1:0]    chk_blk;
    logic [LANE_W-1:0]  chk_lane;

    brd_req_check #(
        .OFS_W(OFS_W), .LEN_W(LEN_W), .WINDOW(WINDOW), .BASE(BASE),
        .BLOCK(BLOCK), .WA_W(WA_W), .LANE_W(LANE_W)
    ) u_check (
        .ofs(req_offset), .size(req_size),
        .bad(chk_bad), .start_blk(chk_blk), .start_lane(chk_lane)
    );

    brd_lane_pick #(.BLOCK(BLOCK), .LANE_W(LANE_W)) u_pick (
        .word(word_q), .lane(lane_q), .pick(byte_data)
    );

    // Port outputs decoded from the controller state.
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        wrd_req_valid = (state_q == ST_ASK);
        wrd_req_addr  = blk_q;
        byte_valid    = (state_q == ST_SEND);
        byte_last     = (left_q == LEN_W'(1));
        stat_valid    = (state_q == ST_DONE);
        stat_code     = code_q;
        stat_count    = count_q;
    end

    // Request controller: check, fetch, stream, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            blk_q   <= '0;
            lane_q  <= '0;
            left_q  <= '0;
            sent_q  <= '0;
            count_q <= '0;
            code_q  <= CODE_OK;
            word_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    if (chk_bad) begin
                        code_q  <= CODE_BADARG;
                        count_q <= '0;
                        state_q <= ST_DONE;
                    end else begin
                        blk_q   <= chk_blk;
                        lane_q  <= chk_lane;
                        left_q  <= req_size;
                        sent_q  <= '0;
                        state_q <= ST_ASK;
                    end
                end
                ST_ASK: if (wrd_req_ready) state_q <= ST_WAIT;
                ST_WAIT: if (wrd_rsp_valid) begin
                    if (wrd_rsp_err) begin
                        code_q  <= wrd_rsp_code;
                        count_q <= sent_q;
                        state_q <= ST_DONE;
                    end else begin
                        word_q  <= wrd_rsp_data;
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: if (byte_ready) begin
                    sent_q <= sent_q + LEN_W'(1);
                    left_q <= left_q - LEN_W'(1);
                    if (left_q == LEN_W'(1)) begin
                        code_q  <= CODE_OK;
                        count_q <= sent_q + LEN_W'(1);
                        state_q <= ST_DONE;
                    end else if (lane_q == LANE_TOP) begin
                        lane_q  <= '0;
                        blk_q   <= blk_q + WA_W'(1);
                        state_q <= ST_ASK;
                    end else begin
                        lane_q <= lane_q + LANE_W'(1);
                    end
                end
                ST_DONE: if (stat_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R10: no request is taken while any later phase is in progress.
    a_r10_busy_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid || wrd_req_valid || stat_valid) |-> !req_ready);

    // R11: a stalled byte holds its data and last flag.
    a_r11_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data) && $stable(byte_last)));

    // R12: a stalled word request holds its address.
    a_r12_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wrd_req_valid && !wrd_req_ready) |=> (wrd_req_valid && $stable(wrd_req_addr)));

    // R9: a failed word goes straight to status with the reader's code.
    a_r9_err_to_status: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && wrd_rsp_valid && wrd_rsp_err)
            |=> (stat_valid && !wrd_req_valid && !byte_valid && stat_code == $past(wrd_rsp_code)));

    // R8: the last byte taken is followed by a success status.
    a_r8_last_then_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_ready && byte_last) |=> (stat_valid && stat_code == CODE_OK));
endmodule

// File: tb/sim_byte_window_reader.sv
module sim_byte_window_reader;
    localparam int OFS_W  = 8;
    localparam int LEN_W  = 8;
    localparam int WINDOW = 16;
    localparam int BASE   = 6;
    localparam int BLOCK  = 4;
    localparam int WA_W   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, byte_ready = 1'b0, stat_ready = 1'b0;
    logic wrd_req_ready = 1'b0, wrd_rsp_valid = 1'b0, wrd_rsp_err = 1'b0;
    logic [OFS_W-1:0] req_offset = '0;
    logic [LEN_W-1:0] req_size = '0;
    logic [31:0] wrd_rsp_data = '0;
    logic [7:0]  wrd_rsp_code = '0;
    logic req_ready, byte_valid, byte_last, stat_valid, wrd_req_valid;
    logic [7:0] byte_data, stat_code;
    logic [LEN_W-1:0] stat_count;
    logic [WA_W-1:0] wrd_req_addr;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    byte_window_reader #(
        .OFS_W(OFS_W), .LEN_W(LEN_W), .WINDOW(WINDOW), .BASE(BASE),
        .BLOCK(BLOCK), .WA_W(WA_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_offset(req_offset), .req_size(req_size),
        .byte_valid(byte_valid), .byte_ready(byte_ready),
        .byte_data(byte_data), .byte_last(byte_last),
        .stat_valid(stat_valid), .stat_ready(stat_ready),
        .stat_code(stat_code), .stat_count(stat_count),
        .wrd_req_valid(wrd_req_valid), .wrd_req_ready(wrd_req_ready),
        .wrd_req_addr(wrd_req_addr),
        .wrd_rsp_valid(wrd_rsp_valid), .wrd_rsp_data(wrd_rsp_data),
        .wrd_rsp_err(wrd_rsp_err), .wrd_rsp_code(wrd_rsp_code)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [7:0] memb(int b);
        return 8'((b * 37 + 11) & 255);
    endfunction

    function automatic logic [31:0] memw(int w);
        return {memb(4*w+3), memb(4*w+2), memb(4*w+1), memb(4*w)};
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // One request; err_blk < 0 means the reader never fails; mode 1 adds stalls.
    task automatic run_req(int o, int s, int err_blk, logic [7:0] ecode, int mode);
        int a = o + BASE;
        int first = (o + BASE) / BLOCK;
        int endb = (o + BASE + s + BLOCK - 1) / BLOCK;
        bit bad = (o < 0) || (s <= 0) || (o + s > WINDOW);
        bit eb_hit = !bad && err_blk >= first && err_blk < endb;
        int nbytes = 0, nwords = 0, cd = -1, pend = 0;
        bit done = 0, seen_last = 0, bstall = 0, wstall = 0;
        logic [7:0] bprev = '0;
        logic bprev_last = 1'b0;
        logic [WA_W-1:0] aprev = '0;
        int exp_code, exp_cnt, exp_words;
        if (bad) begin
            exp_code = 22; exp_cnt = 0; exp_words = 0;
        end else if (eb_hit) begin
            exp_code = ecode;
            exp_cnt = (err_blk * BLOCK - a > 0) ? err_blk * BLOCK - a : 0;
            exp_words = err_blk - first + 1;
        end else begin
            exp_code = 0; exp_cnt = s; exp_words = endb - first;
        end
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 idle ready", req_ready, 1);
        req_valid = 1'b1; req_offset = OFS_W'(o); req_size = LEN_W'(s);
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 400 && !done; c++) begin
            byte_ready    = (mode == 0) ? 1'b1 : ((c % 3) != 1);
            wrd_req_ready = (mode == 0) ? 1'b1 : ((c % 4) != 2);
            stat_ready    = (mode == 0) ? 1'b1 : ((c % 2) == 1);
            wrd_rsp_valid = 1'b0; wrd_rsp_err = 1'b0;
            if (cd == 0) begin
                wrd_rsp_valid = 1'b1;
                wrd_rsp_data  = memw(pend);
                wrd_rsp_err   = (pend == err_blk);
                wrd_rsp_code  = (pend == err_blk) ? ecode : 8'd0;
                cd = -1;
            end else if (cd > 0) cd = cd - 1;
            #1;
            chk(req_ready == 1'b0, "R10 busy not ready", req_ready, 0);
            if (bstall) begin
                chk(byte_valid && byte_data == bprev && byte_last == bprev_last,
                    "R11 byte held", byte_data, bprev);
            end
            if (wstall) chk(wrd_req_valid && wrd_req_addr == aprev, "R12 addr held", wrd_req_addr, aprev);
            bstall = byte_valid && !byte_ready; bprev = byte_data; bprev_last = byte_last;
            wstall = wrd_req_valid && !wrd_req_ready; aprev = wrd_req_addr;
            if (byte_valid && byte_ready) begin
                chk(byte_data == memb(a + nbytes), "R6 byte value", byte_data, memb(a + nbytes));
                chk(byte_last == (nbytes == s - 1), "R7 last flag", byte_last, nbytes == s - 1);
                if (byte_last) seen_last = 1;
                nbytes++;
            end
            if (wrd_req_valid && wrd_req_ready) begin
                chk(int'(wrd_req_addr) == first + nwords, "R5 word address", wrd_req_addr, first + nwords);
                pend = int'(wrd_req_addr);
                nwords++;
                cd = (mode == 0) ? 0 : 1;
            end
            if (stat_valid && stat_ready) begin
                chk(int'(stat_code) == exp_code, "R2 R3 R8 R9 status code", stat_code, exp_code);
                chk(int'(stat_count) == exp_cnt, "R8 R9 status count", stat_count, exp_cnt);
                done = 1;
            end
            @(negedge clk);
        end
        wrd_rsp_valid = 1'b0; wrd_rsp_err = 1'b0;
        chk(done, "R8 status reached", done, 1);
        chk(nwords == exp_words, "R4 R5 R9 word request count", nwords, exp_words);
        chk(nbytes == exp_cnt, "R7 R9 byte count", nbytes, exp_cnt);
        if (bad || eb_hit) chk(!seen_last, "R9 no last flag", seen_last, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(!byte_valid && !stat_valid && !wrd_req_valid, "R1 outputs idle", 1, 0);
        // R2 R3 R4 R5 R6 R7 R8 R11 R12: sweep offsets and sizes across both window edges.
        for (int m = 0; m < 2; m++)
            for (int o = -3; o <= 18; o++)
                for (int s = -2; s <= 19; s++)
                    run_req(o, s, -1, 8'd0, m);
        // R2 R3 R4: extreme encodings of offset and size.
        run_req(127, 1, -1, 8'd0, 1);
        run_req(-128, 4, -1, 8'd0, 0);
        run_req(1, -128, -1, 8'd0, 0);
        run_req(0, 127, -1, 8'd0, 1);
        run_req(0, 16, -1, 8'd0, 1);
        // R9: reader error on each covering word in turn.
        for (int o = 0; o < WINDOW; o++)
            for (int s = 1; s <= WINDOW - o; s++)
                for (int eb = (o + BASE) / BLOCK; eb < (o + BASE + s + BLOCK - 1) / BLOCK; eb++)
                    run_req(o, s, eb, 8'(8'h41 + eb), (o + s) % 2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule